// File: doc/BRIEF.md
# Protected SMM Region Access Filter

This block sits in the memory request path of a memory controller. It examines every request against a protected system-management region placed at the top of low memory and decides how the request reaches DRAM. The region lies directly below the graphics stolen memory, which itself occupies the highest megabytes of physical memory. The region's base is recomputed combinationally from the configuration inputs, so it always follows the current configuration.

A request that hits the enabled region is never dropped. Depending on the initiator and the attributes the request carries, it is passed through unchanged, rewritten into an invalid cycle (address forced to zero, write byte enables cleared), or tagged as a coherency completion that still writes main memory. Results leave through a single output register with a valid/ready handshake, one cycle after acceptance.

Addresses are compared at megabyte granularity (`MB_SHIFT` low bits ignored). The top of memory is given in megabytes and is one bit wider than the megabyte part of the address, so a full 4 GB space can be described.

Top module: `smm_access_filter`

## Requirements
- R1: With top-of-memory T MB, graphics size G MB and region size S MB, a request hits when T-G-S <= addr>>MB_SHIFT < T-G; addresses just below the base and at the graphics base miss.
- R2: Region size select codes 0, 1, 2 give 1, 2 and 8 MB; code 3 gives an empty region that no address hits.
- R3: Graphics size select codes 0..6 give 0, 1, 4, 8, 16, 32 and 64 MB; code 7 gives 0 MB.
- R4: With the region enable low, every request leaves with action PASS (code 0) and address, byte enables and direction unchanged.
- R5: A hit from a non-processor initiator leaves with action INVALID (code 1) and address 0; a write also has all byte enables cleared, a read keeps its byte enables.
- R6: A processor hit carrying both the SMM and the write-back attribute leaves with action PASS at the same address.
- R7: A processor hit carrying the write-back attribute but not the SMM attribute leaves with action COHERENT (code 2), address and byte enables unchanged; only processor requests can produce COHERENT.
- R8: A processor hit carrying the SMM attribute but not write-back becomes INVALID when extended mode is on, and PASS when it is off.
- R9: A processor hit with neither attribute becomes INVALID.
- R10: A request that misses the region leaves with action PASS and all fields unchanged.
- R11: An accepted request appears at the output on the next cycle; while the output is valid and not taken, it holds steady and no new request is accepted; requests leave in acceptance order.
- R12: When T is smaller than G+S the region does not exist and no address hits.
- R13: During reset the output is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgTopMb | input | ADDR_W-MB_SHIFT+1 | Top of physical memory in MB |
| cfgGfxSel | input | 3 | Graphics stolen size select |
| cfgRegSel | input | 2 | Protected region size select |
| cfgRegionEn | input | 1 | Protected region enable |
| cfgExtEn | input | 1 | Extended mode enable |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqAddr | input | ADDR_W | Request address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBe | input | BE_W | Request byte enables |
| reqFromCpu | input | 1 | 1 = processor initiator, 0 = any other agent |
| reqSmm | input | 1 | SMM attribute |
| reqWb | input | 1 | Write-back attribute |
| outValid | output | 1 | Filtered request valid |
| outReady | input | 1 | Downstream takes the filtered request |
| outAddr | output | ADDR_W | Filtered address |
| outWrite | output | 1 | Filtered direction |
| outBe | output | BE_W | Filtered byte enables |
| outAction | output | 2 | 0 PASS, 1 INVALID, 2 COHERENT |

## Verification
The bench builds the block with its defaults, a 32-bit address, 8 byte enables and 1 MB granularity, which makes the 13-bit top-of-memory field able to reach 4096 MB so the region can sit at the very top of the address space. With these values every graphics and region size code, the underflow case where the sizes exceed memory, and both edges of the region in each configuration are reachable by directed requests, while random traffic biased near the top of memory mixes all initiator and attribute combinations under random downstream stalls.

// File: rtl/smm_filter_pkg.sv
package smm_filter_pkg;

  typedef enum logic [1:0] {
    ACT_PASS     = 2'd0,
    ACT_INVALID  = 2'd1,
    ACT_COHERENT = 2'd2
  } fwdAction_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       zeroAddr;
    logic       clearBe;
    fwdAction_e action;
  } filterStrobe_t;

  function automatic logic [6:0] gfxStolenMb(input logic [2:0] sel);
    logic [6:0] mb;
    case (sel)
      3'd1:    mb = 7'd1;
      3'd2:    mb = 7'd4;
      3'd3:    mb = 7'd8;
      3'd4:    mb = 7'd16;
      3'd5:    mb = 7'd32;
      3'd6:    mb = 7'd64;
      default: mb = 7'd0;
    endcase
    return mb;
  endfunction

  function automatic logic [3:0] guardSizeMb(input logic [1:0] sel);
    logic [3:0] mb;
    case (sel)
      2'd0:    mb = 4'd1;
      2'd1:    mb = 4'd2;
      2'd2:    mb = 4'd8;
      default: mb = 4'd0;
    endcase
    return mb;
  endfunction

endpackage

// File: rtl/smm_filter_ctrl.sv
module smm_filter_ctrl
  import smm_filter_pkg::*;
(
  input  logic          reqValid,
  input  logic          outValid,
  input  logic          outReady,
  input  logic          regionHit,
  input  logic          cfgRegionEn,
  input  logic          cfgExtEn,
  input  logic          reqWrite,
  input  logic          reqFromCpu,
  input  logic          reqSmm,
  input  logic          reqWb,
  output logic          reqReady,
  output filterStrobe_t strobe
);

  fwdAction_e decided;

  // single output stage: free when empty or being drained
  assign reqReady = !outValid || outReady;

  always_comb begin
    if (!cfgRegionEn || !regionHit) begin
      decided = ACT_PASS;
    end else if (!reqFromCpu) begin
      decided = ACT_INVALID;
    end else if (reqSmm && reqWb) begin
      decided = ACT_PASS;
    end else if (reqWb) begin
      decided = ACT_COHERENT;
    end else if (!reqSmm) begin
      decided = ACT_INVALID;
    end else begin
      decided = cfgExtEn ? ACT_INVALID : ACT_PASS;
    end
  end

  always_comb begin
    strobe.load     = reqValid && reqReady;
    strobe.action   = decided;
    strobe.zeroAddr = (decided == ACT_INVALID);
    strobe.clearBe  = (decided == ACT_INVALID) && reqWrite;
  end

endmodule

// File: rtl/smm_filter_dp.sv
module smm_filter_dp
  import smm_filter_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BE_W     = 8,
  parameter int MB_SHIFT = 20
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-MB_SHIFT:0]   cfgTopMb,
  input  logic [2:0]                 cfgGfxSel,
  input  logic [1:0]                 cfgRegSel,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic                       reqWrite,
  input  logic [BE_W-1:0]            reqBe,
  input  filterStrobe_t              strobe,
  input  logic                       outReady,
  output logic                       regionHit,
  output logic                       outValid,
  output logic [ADDR_W-1:0]          outAddr,
  output logic                       outWrite,
  output logic [BE_W-1:0]            outBe,
  output logic [1:0]                 outAction
);

  localparam int MB_W  = ADDR_W - MB_SHIFT;
  localparam int TOP_W = MB_W + 1;

  logic [TOP_W-1:0] gfxMb, guardMb, sumMb, baseMb, gfxBaseMb, addrMb;
  logic             fits;

  always_comb begin
    gfxMb     = TOP_W'(gfxStolenMb(cfgGfxSel));
    guardMb   = TOP_W'(guardSizeMb(cfgRegSel));
    sumMb     = gfxMb + guardMb;
    fits      = (cfgTopMb >= sumMb);
    gfxBaseMb = cfgTopMb - gfxMb;
    baseMb    = cfgTopMb - sumMb;
    addrMb    = {1'b0, reqAddr[ADDR_W-1:MB_SHIFT]};
    regionHit = fits && (addrMb >= baseMb) && (addrMb < gfxBaseMb);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outAddr   <= '0;
      outWrite  <= 1'b0;
      outBe     <= '0;
      outAction <= ACT_PASS;
    end else begin
      if (strobe.load) begin
        outValid  <= 1'b1;
        outAddr   <= strobe.zeroAddr ? '0 : reqAddr;
        outWrite  <= reqWrite;
        outBe     <= strobe.clearBe ? '0 : reqBe;
        outAction <= strobe.action;
      end else if (outReady) begin
        outValid  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/smm_access_filter.sv
module smm_access_filter
  import smm_filter_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BE_W     = 8,
  parameter int MB_SHIFT = 20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-MB_SHIFT:0] cfgTopMb,
  input  logic [2:0]               cfgGfxSel,
  input  logic [1:0]               cfgRegSel,
  input  logic                     cfgRegionEn,
  input  logic                     cfgExtEn,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic                     reqWrite,
  input  logic [BE_W-1:0]          reqBe,
  input  logic                     reqFromCpu,
  input  logic                     reqSmm,
  input  logic                     reqWb,
  output logic                     outValid,
  input  logic                     outReady,
  output logic [ADDR_W-1:0]        outAddr,
  output logic                     outWrite,
  output logic [BE_W-1:0]          outBe,
  output logic [1:0]               outAction
);

  filterStrobe_t strobe;
  logic          regionHit;

  smm_filter_ctrl u_ctrl (
    .reqValid    (reqValid),
    .outValid    (outValid),
    .outReady    (outReady),
    .regionHit   (regionHit),
    .cfgRegionEn (cfgRegionEn),
    .cfgExtEn    (cfgExtEn),
    .reqWrite    (reqWrite),
    .reqFromCpu  (reqFromCpu),
    .reqSmm      (reqSmm),
    .reqWb       (reqWb),
    .reqReady    (reqReady),
    .strobe      (strobe)
  );

  smm_filter_dp #(
    .ADDR_W   (ADDR_W),
    .BE_W     (BE_W),
    .MB_SHIFT (MB_SHIFT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgTopMb  (cfgTopMb),
    .cfgGfxSel (cfgGfxSel),
    .cfgRegSel (cfgRegSel),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite),
    .reqBe     (reqBe),
    .strobe    (strobe),
    .outReady  (outReady),
    .regionHit (regionHit),
    .outValid  (outValid),
    .outAddr   (outAddr),
    .outWrite  (outWrite),
    .outBe     (outBe),
    .outAction (outAction)
  );

endmodule

// File: rtl/smm_filter_chk.sv
module smm_filter_chk
  import smm_filter_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgRegionEn,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [BE_W-1:0]   reqBe,
  input logic              reqFromCpu,
  input logic              outValid,
  input logic              outReady,
  input logic [ADDR_W-1:0] outAddr,
  input logic              outWrite,
  input logic [BE_W-1:0]   outBe,
  input logic [1:0]        outAction
);

  assert_reset_idle_R13: assert property (@(posedge clk)
    !rstN |=> !outValid);

  assert_one_cycle_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> outValid);

  assert_hold_stall_R11: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outAddr) && $stable(outBe)
                              && $stable(outAction) && $stable(outWrite));

  assert_invalid_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outAction == ACT_INVALID |-> outAddr == '0);

  assert_invalid_be_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outAction == ACT_INVALID && outWrite |-> outBe == '0);

  assert_bypass_R4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !cfgRegionEn |=>
      outAction == ACT_PASS && outAddr == $past(reqAddr) && outBe == $past(reqBe));

  assert_coherent_cpu_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !reqFromCpu |=> outAction != ACT_COHERENT);

endmodule

bind smm_access_filter smm_filter_chk #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgRegionEn (cfgRegionEn),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqAddr     (reqAddr),
  .reqBe       (reqBe),
  .reqFromCpu  (reqFromCpu),
  .outValid    (outValid),
  .outReady    (outReady),
  .outAddr     (outAddr),
  .outWrite    (outWrite),
  .outBe       (outBe),
  .outAction   (outAction)
);

// File: tb/test_smm_access_filter.sv
module test_smm_access_filter;

  localparam int AW = 32;
  localparam int BW = 8;
  localparam int SH = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [12:0]   cfgTopMb = 13'd64;
  logic [2:0]    cfgGfxSel = 3'd1;
  logic [1:0]    cfgRegSel = 2'd0;
  logic          cfgRegionEn = 1'b1;
  logic          cfgExtEn = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [AW-1:0] reqAddr = '0;
  logic          reqWrite = 1'b0;
  logic [BW-1:0] reqBe = '0;
  logic          reqFromCpu = 1'b0;
  logic          reqSmm = 1'b0;
  logic          reqWb = 1'b0;
  logic          outValid;
  logic          outReady = 1'b1;
  logic [AW-1:0] outAddr;
  logic          outWrite;
  logic [BW-1:0] outBe;
  logic [1:0]    outAction;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string curTag = "";

  typedef struct {
    logic [AW-1:0] addr;
    logic          wr;
    logic [BW-1:0] be;
    int            act;
    string         tag;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  smm_access_filter #(.ADDR_W(AW), .BE_W(BW), .MB_SHIFT(SH)) i_smm_access_filter (
    .clk(clk), .rstN(rstN), .cfgTopMb(cfgTopMb), .cfgGfxSel(cfgGfxSel),
    .cfgRegSel(cfgRegSel), .cfgRegionEn(cfgRegionEn), .cfgExtEn(cfgExtEn),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqBe(reqBe), .reqFromCpu(reqFromCpu),
    .reqSmm(reqSmm), .reqWb(reqWb), .outValid(outValid), .outReady(outReady),
    .outAddr(outAddr), .outWrite(outWrite), .outBe(outBe), .outAction(outAction)
  );

  // expected behaviour from the requirements
  function automatic exp_t model();
    exp_t e;
    int gMb, sMb;
    longint hiMb, loMb, aMb;
    bit hit;
    case (cfgGfxSel)                       // R3 size codes
      3'd0: gMb = 0;  3'd1: gMb = 1;  3'd2: gMb = 4;  3'd3: gMb = 8;
      3'd4: gMb = 16; 3'd5: gMb = 32; 3'd6: gMb = 64; default: gMb = 0;
    endcase
    case (cfgRegSel)                       // R2 size codes
      2'd0: sMb = 1; 2'd1: sMb = 2; 2'd2: sMb = 8; default: sMb = 0;
    endcase
    hiMb = longint'(cfgTopMb) - gMb;
    loMb = hiMb - sMb;
    aMb  = longint'(reqAddr >> SH);
    hit  = (loMb >= 0) && (aMb >= loMb) && (aMb < hiMb);   // R1, R12
    e.addr = reqAddr; e.wr = reqWrite; e.be = reqBe; e.act = 0;
    if (!cfgRegionEn) e.tag = "R4";
    else if (!hit) e.tag = "R10";
    else if (!reqFromCpu) begin
      e.tag = "R5"; e.act = 1; e.addr = '0;
      if (reqWrite) e.be = '0;
    end else if (reqSmm && reqWb) e.tag = "R6";
    else if (!reqSmm && reqWb) begin e.tag = "R7"; e.act = 2; end
    else if (!reqSmm) begin
      e.tag = "R9"; e.act = 1; e.addr = '0;
      if (reqWrite) e.be = '0;
    end else begin
      e.tag = "R8";
      if (cfgExtEn) begin
        e.act = 1; e.addr = '0;
        if (reqWrite) e.be = '0;
      end
    end
    if (curTag != "") e.tag = {curTag, "/", e.tag};
    return e;
  endfunction

  // monitor: after all negedge drives, score the transfer and the acceptance
  always @(negedge clk) begin
    #2;
    if (rstN && !finished) begin
      if (outValid && outReady) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R11: unexpected output addr %h act %0d, expected none", outAddr, outAction);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (outAddr !== e.addr || outBe !== e.be || outWrite !== e.wr || int'(outAction) != e.act) begin
            errors++;
            $display("FAIL %s: addr %h be %h wr %b act %0d, expected addr %h be %h wr %b act %0d",
                     e.tag, outAddr, outBe, outWrite, outAction, e.addr, e.be, e.wr, e.act);
          end
        end
      end
      if (reqValid && reqReady) q.push_back(model());
    end
  end

  task automatic send(input logic [AW-1:0] a, input logic wr, input logic [BW-1:0] be,
                      input logic cpu, input logic smm, input logic wb);
    @(negedge clk);
    reqValid = 1'b1; outReady = 1'b1;
    reqAddr = a; reqWrite = wr; reqBe = be; reqFromCpu = cpu; reqSmm = smm; reqWb = wb;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic setCfg(input logic [12:0] top, input logic [2:0] g, input logic [1:0] s,
                        input logic en, input logic ext);
    @(negedge clk);
    reqValid = 1'b0;
    cfgTopMb = top; cfgGfxSel = g; cfgRegSel = s; cfgRegionEn = en; cfgExtEn = ext;
  endtask

  task automatic drainCheck();
    outReady = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R11: %0d outputs pending, expected 0", q.size());
    end
  endtask

  function automatic logic [AW-1:0] mbAddr(input int mb, input int off);
    return (AW'(mb) << SH) + AW'(off);
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R13: outValid %b during reset, expected 0", outValid);
    end
    rstN = 1'b1;

    // 64 MB memory, 1 MB graphics, 1 MB region: region is MB 62
    curTag = "R1";
    setCfg(13'd64, 3'd1, 2'd0, 1'b1, 1'b0);
    send(32'h03DF_FFFF, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    send(32'h03E0_0000, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    send(32'h03EF_FFFF, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    send(32'h03F0_0000, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    curTag = "";
    send(32'h03E8_0040, 1'b0, 8'h0F, 1'b0, 1'b0, 1'b0);   // R5 read keeps be
    send(32'h03E8_0040, 1'b0, 8'h3C, 1'b1, 1'b1, 1'b1);   // R6
    send(32'h03E8_0080, 1'b1, 8'hF0, 1'b1, 1'b0, 1'b1);   // R7
    send(32'h03E8_00C0, 1'b1, 8'h81, 1'b1, 1'b1, 1'b0);   // R8 ext off
    send(32'h03E8_0100, 1'b1, 8'h18, 1'b1, 1'b0, 1'b0);   // R9
    setCfg(13'd64, 3'd1, 2'd0, 1'b1, 1'b1);
    send(32'h03E8_00C0, 1'b1, 8'h81, 1'b1, 1'b1, 1'b0);   // R8 ext on
    setCfg(13'd64, 3'd1, 2'd0, 1'b0, 1'b1);
    send(32'h03E8_0000, 1'b1, 8'hAA, 1'b0, 1'b0, 1'b0);   // R4
    drainCheck();

    // 256 MB, 64 MB graphics, 8 MB region: region MB 184..191
    curTag = "R2_R3";
    setCfg(13'd256, 3'd6, 2'd2, 1'b1, 1'b0);
    send(mbAddr(183, 32'hF_FFFF), 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    send(mbAddr(184, 0), 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    send(mbAddr(191, 32'hF_FFF0), 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    send(mbAddr(192, 0), 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    setCfg(13'd256, 3'd3, 2'd1, 1'b1, 1'b0);              // 8 MB gfx, 2 MB region: 246..247
    send(mbAddr(245, 32'h8_0000), 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    send(mbAddr(246, 0), 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    send(mbAddr(247, 32'h8_0000), 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    setCfg(13'd256, 3'd7, 2'd3, 1'b1, 1'b0);              // empty region, gfx code 7
    send(mbAddr(255, 0), 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    send(mbAddr(254, 0), 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    curTag = "R12";
    setCfg(13'd40, 3'd6, 2'd0, 1'b1, 1'b0);
    send(mbAddr(0, 16), 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    send(mbAddr(39, 0), 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    curTag = "R1";
    setCfg(13'd4096, 3'd0, 2'd0, 1'b1, 1'b0);
    send(32'hFFF0_0000, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    send(32'hFFEF_FFFF, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    curTag = "";
    drainCheck();

    // stalled output: R11 hold and ordering
    curTag = "R11";
    setCfg(13'd64, 3'd1, 2'd0, 1'b1, 1'b0);
    @(negedge clk);
    reqValid = 1'b1; outReady = 1'b0;
    reqAddr = 32'h03E1_2340; reqWrite = 1'b1; reqBe = 8'h55;
    reqFromCpu = 1'b0; reqSmm = 1'b0; reqWb = 1'b0;
    @(negedge clk);
    reqAddr = 32'h0000_1000;
    repeat (4) @(negedge clk);
    outReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    curTag = "";
    drainCheck();

    // constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 99) < 2) begin
        cfgTopMb    = 13'($urandom_range(16, 4096));
        cfgGfxSel   = 3'($urandom_range(0, 7));
        cfgRegSel   = 2'($urandom_range(0, 3));
        cfgRegionEn = ($urandom_range(0, 9) != 0);
        cfgExtEn    = 1'($urandom_range(0, 1));
      end
      reqValid   = ($urandom_range(0, 99) < 70);
      outReady   = ($urandom_range(0, 99) < 75);
      begin
        int back = $urandom_range(0, 80);
        int mb = int'(cfgTopMb) - back;
        if (mb < 0) mb = 0;
        reqAddr = mbAddr(mb, int'($urandom_range(0, (1 << SH) - 1)));
      end
      reqWrite   = 1'($urandom_range(0, 1));
      reqBe      = BW'($urandom);
      reqFromCpu = 1'($urandom_range(0, 1));
      reqSmm     = 1'($urandom_range(0, 1));
      reqWb      = 1'($urandom_range(0, 1));
    end
    @(negedge clk);
    reqValid = 1'b0;
    drainCheck();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule